// File: doc/BRIEF.md
# Horizontal Sync Regenerator with Half-Line Eliminator

This block takes a one-bit, active-low composite sync signal that an external comparator has already sliced, samples it on the system clock, and rebuilds two timing pulses from it. The first is a clean, active-high horizontal sync train that carries only true line-rate pulses. The equalizing and serration pulses, which arrive at half-line spacing during vertical blanking, are dropped. The second is an active-high back-porch gate for DC restore of the video level.

Each accepted sync leading edge starts a horizontal pulse of fixed width, whatever the width of the input pulse. After an accepted edge, a line-window counter ignores further leading edges for three quarters of a nominal line. The same counter saturates at five quarters of a line, so a lost signal is picked up again on its first edge. The back-porch one-shot fires on the trailing edge of an accepted pulse. It also fires on the trailing edge of any broad pulse, which is how serrations in the vertical interval are recognised. Every timing constant is a parameter in clock cycles. The defaults suit a 27 MHz clock and a 15.734 kHz line rate.

Top module: `hsync_regen`

## Requirements
- R1: While `rst_n` is low, both outputs are low in the cycle after each clock edge, and they stay low after reset until the first input pulse.
- R2: The input passes through a two-flop synchronizer. A horizontal pulse rises at the third clock edge after the input falls, and the back-porch pulse rises at the third clock edge after the input rises.
- R3: Every horizontal pulse is exactly `HS_WIDTH` cycles high, for any input low width from 1 cycle upward.
- R4: With `LOCKOUT = LINE_CYC*3/4`, a falling edge that comes `LOCKOUT` cycles or less after the last accepted falling edge is ignored. One that comes `LOCKOUT+1` cycles or more after it is accepted.
- R5: With `TIMEOUT = LINE_CYC*5/4`, the first falling edge after reset is accepted at once. So is the first falling edge after `TIMEOUT` or more idle cycles.
- R6: In a train of short pulses at half-line spacing, only every second pulse, the line-rate one, produces a horizontal pulse.
- R7: The back-porch output is a one-shot exactly `BP_WIDTH` cycles high. It is triggered by the rising edge of an accepted pulse.
- R8: The rising edge of a rejected pulse triggers the back-porch one-shot only if that pulse stayed low for at least `BROAD_MIN` cycles (a serration). A short rejected pulse leaves `bporch_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csync_n | input | 1 | Sliced composite sync, active low, asynchronous to `clk` |
| hsync_o | output | 1 | Regenerated horizontal sync, active high |
| bporch_o | output | 1 | Back-porch gate, active high |

## Verification
The bench sweeps the spacing between two edges across the lockout limit, with both sides of `LOCKOUT+1`. A design with an off-by-one in the window would pass or drop the edge that sits on the limit. It sweeps the input low width from one cycle upward, which exposes a horizontal pulse that follows the input width instead of its own timer. It also runs equalizing and serration trains. There, a design that does not track broad pulses would lose the back-porch pulses of the serrations, and a design that does not suppress half-line edges would double the horizontal rate. A long idle gap and a reset in the middle of a pulse check that the block reacquires at once and that it clears its outputs.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    // Edge events derived from the synchronized sync level
    typedef struct packed {
        logic fall;
        logic rise;
    } sync_edge_t;

    function automatic sync_edge_t edges_of(input logic prev, input logic cur);
        sync_edge_t e;
        e.fall = prev & ~cur;
        e.rise = ~prev & cur;
        return e;
    endfunction

endpackage

// File: rtl/hsr_sync2.sv
module hsr_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic meta;
        logic stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta = d;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{meta: 1'b1, stab: 1'b1};
        else        st_q <= st_d;
    end

    assign q = st_q.stab;
endmodule

// File: rtl/hsr_oneshot.sv
module hsr_oneshot #(
    parameter int WIDTH = 135
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (trig)              cnt_d = CW'(WIDTH);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/hsr_line_gate.sv
module hsr_line_gate #(
    parameter int LOCKOUT = 1287,
    parameter int TIMEOUT = 2145
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    output logic accept
);
    localparam int GW = $clog2(TIMEOUT + 1);

    logic [GW-1:0] age_d, age_q;

    // Edge accepted once the window since the last accepted edge has opened;
    // the age saturates at TIMEOUT, so a lost signal is taken at once.
    assign accept = fall && (age_q >= GW'(LOCKOUT));

    always_comb begin
        if (accept)                   age_d = '0;
        else if (age_q < GW'(TIMEOUT)) age_d = age_q + 1'b1;
        else                          age_d = age_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= GW'(TIMEOUT);
        else        age_q <= age_d;
    end
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen #(
    parameter int LINE_CYC  = 1716,
    parameter int HS_WIDTH  = 135,
    parameter int BP_WIDTH  = 81,
    parameter int BROAD_MIN = LINE_CYC / 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic hsync_o,
    output logic bporch_o
);
    import hsr_pkg::*;

    localparam int LOCKOUT = (LINE_CYC * 3) / 4;
    localparam int TIMEOUT = (LINE_CYC * 5) / 4;
    localparam int WW      = $clog2(BROAD_MIN + 1);

    typedef struct packed {
        logic          prev;   // synchronized level one cycle ago
        logic [WW-1:0] low_w;  // low duration of current pulse, saturating
        logic          pend;   // current pulse was accepted as a line edge
    } top_st_t;

    top_st_t    st_d, st_q;
    logic       sync_s;
    sync_edge_t edg;
    logic       hs_accept;
    logic       bp_trig;
    logic       broad;

    hsr_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (csync_n),
        .q     (sync_s)
    );

    assign edg   = edges_of(st_q.prev, sync_s);
    assign broad = (st_q.low_w >= WW'(BROAD_MIN));

    hsr_line_gate #(
        .LOCKOUT (LOCKOUT),
        .TIMEOUT (TIMEOUT)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall   (edg.fall),
        .accept (hs_accept)
    );

    assign bp_trig = edg.rise && (st_q.pend || broad);

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_s;
        if (edg.fall)
            st_d.low_w = WW'(1);
        else if (!sync_s && !broad)
            st_d.low_w = st_q.low_w + 1'b1;
        if (hs_accept)
            st_d.pend = 1'b1;
        else if (edg.rise)
            st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{prev: 1'b1, low_w: '0, pend: 1'b0};
        else        st_q <= st_d;
    end

    hsr_oneshot #(.WIDTH(HS_WIDTH)) u_hs_shot (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (hs_accept),
        .active (hsync_o)
    );

    hsr_oneshot #(.WIDTH(BP_WIDTH)) u_bp_shot (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (bp_trig),
        .active (bporch_o)
    );
endmodule

// File: rtl/hsync_regen_chk.sv
module hsync_regen_chk #(
    parameter int HS_WIDTH = 135,
    parameter int LOCKOUT  = 1287,
    parameter int TIMEOUT  = 2145
) (
    input logic clk,
    input logic rst_n,
    input logic hsync_o,
    input logic bporch_o,
    input logic accept,
    input logic bp_trig
);
    localparam int SW = $clog2(TIMEOUT + 1);
    localparam int RW = $clog2(HS_WIDTH + 2);

    logic          hs_prev_q;
    logic [SW-1:0] since_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_prev_q <= 1'b0;
            since_q   <= SW'(TIMEOUT);
            run_q     <= '0;
        end else begin
            hs_prev_q <= hsync_o;
            if (hsync_o && !hs_prev_q)      since_q <= '0;
            else if (since_q < SW'(TIMEOUT)) since_q <= since_q + 1'b1;
            if (!hsync_o)                   run_q <= '0;
            else if (run_q <= RW'(HS_WIDTH)) run_q <= run_q + 1'b1;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!hsync_o && !bporch_o));

    // R3
    hs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_prev_q && !hsync_o) |-> (run_q == RW'(HS_WIDTH)));

    // R4
    hs_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_o && !hs_prev_q) |-> (since_q >= SW'(LOCKOUT)));

    // R2
    hs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_o) |-> $past(accept));

    // R8
    bp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bporch_o) |-> $past(bp_trig));
endmodule

bind hsync_regen hsync_regen_chk #(
    .HS_WIDTH (HS_WIDTH),
    .LOCKOUT  (LOCKOUT),
    .TIMEOUT  (TIMEOUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync_o  (hsync_o),
    .bporch_o (bporch_o),
    .accept   (hs_accept),
    .bp_trig  (bp_trig)
);

// File: tb/hsync_regen_bench.sv
`timescale 1ns/1ps
module hsync_regen_bench;
    localparam int LINE = 40;
    localparam int HSW  = 5;
    localparam int BPW  = 3;
    localparam int BRD  = 10;
    localparam int LOCK = (LINE * 3) / 4;   // 30
    localparam int TOUT = (LINE * 5) / 4;   // 50

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_n = 1'b1;
    logic hsync_o, bporch_o;

    int cyc = 0;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int hs_rises = 0, hs_rise_t = -1, hs_w = -1;
    int bp_rises = 0, bp_rise_t = -1, bp_w = -1;
    logic hs_prev = 1'b0, bp_prev = 1'b0;
    int t_fall = 0, t_rise = 0;

    always #2 clk = ~clk;

    hsync_regen #(
        .LINE_CYC  (LINE),
        .HS_WIDTH  (HSW),
        .BP_WIDTH  (BPW),
        .BROAD_MIN (BRD)
    ) u_hsync_regen (
        .clk      (clk),
        .rst_n    (rst_n),
        .csync_n  (csync_n),
        .hsync_o  (hsync_o),
        .bporch_o (bporch_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (hsync_o && !hs_prev) begin hs_rises++; hs_rise_t = cyc; end
        if (!hsync_o && hs_prev) hs_w = cyc - hs_rise_t;
        if (bporch_o && !bp_prev) begin bp_rises++; bp_rise_t = cyc; end
        if (!bporch_o && bp_prev) bp_w = cyc - bp_rise_t;
        hs_prev = hsync_o;
        bp_prev = bporch_o;
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int low, input int high);
        csync_n = 1'b0;
        t_fall  = cyc;
        tick(low);
        csync_n = 1'b1;
        t_rise  = cyc;
        tick(high);
    endtask

    task automatic clear_counts();
        hs_rises = 0;
        bp_rises = 0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 outputs low during reset even with input activity
        csync_n = 1'b0;
        tick(4);
        chk("R1 reset hs", int'(hsync_o), 0);
        chk("R1 reset bp", int'(bporch_o), 0);
        csync_n = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(10);
        chk("R1 idle hs", int'(hsync_o), 0);
        chk("R1 idle bp", int'(bporch_o), 0);

        // R5 first edge after reset accepted; R2 latency; R3/R7 widths
        clear_counts();
        pulse(4, 36);
        chk("R5 first edge", hs_rises, 1);
        chk("R2 hs latency", hs_rise_t, t_fall + 3);
        chk("R3 hs width", hs_w, HSW);
        chk("R2 bp latency", bp_rise_t, t_rise + 3);
        chk("R7 bp width", bp_w, BPW);

        // R3 width independent of input low width (sweep 1..17)
        for (int w = 1; w <= 17; w++) begin
            pulse(w, LINE - w);
            chk("R3 hs width sweep", hs_w, HSW);
            chk("R2 hs latency sweep", hs_rise_t, t_fall + 3);
            chk("R7 bp after accepted", bp_rise_t, t_rise + 3);
            chk("R7 bp width sweep", bp_w, BPW);
        end

        // R4 lockout boundary sweep; R8 short rejected pulses give no bp
        for (int d = 20; d <= 44; d++) begin
            tick(TOUT + 10);
            clear_counts();
            pulse(2, d - 2);
            pulse(2, TOUT + 10);
            chk("R4 lockout hs count", hs_rises, (d >= LOCK + 1) ? 2 : 1);
            chk("R8 short rejected bp", bp_rises, (d >= LOCK + 1) ? 2 : 1);
        end

        // R6 equalizing train at half-line spacing
        tick(TOUT + 10);
        clear_counts();
        for (int k = 0; k < 12; k++) pulse(2, LINE / 2 - 2);
        tick(20);
        chk("R6 equalizing hs count", hs_rises, 6);
        chk("R8 equalizing bp count", bp_rises, 6);

        // R8 serration train: every broad rise fires back porch
        tick(TOUT + 10);
        clear_counts();
        for (int k = 0; k < 12; k++) begin
            pulse(15, LINE / 2 - 15);
            if (k == 1) chk("R8 serration bp latency", bp_rise_t, t_rise + 3);
        end
        tick(20);
        chk("R6 serration hs count", hs_rises, 6);
        chk("R8 serration bp count", bp_rises, 12);
        chk("R7 serration bp width", bp_w, BPW);

        // R5 reacquire after long idle gap
        clear_counts();
        pulse(3, 10);
        tick(TOUT + 5);
        pulse(3, 30);
        chk("R5 reacquire count", hs_rises, 2);
        chk("R5 reacquire latency", hs_rise_t, t_fall + 3);

        // R1 reset in the middle of a horizontal pulse
        csync_n = 1'b0;
        tick(4);
        chk("R1 hs high before reset", int'(hsync_o), 1);
        rst_n = 1'b0;
        tick(1);
        chk("R1 mid-pulse reset hs", int'(hsync_o), 0);
        chk("R1 mid-pulse reset bp", int'(bporch_o), 0);
        csync_n = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(5);
        chk("R1 after release", int'(hsync_o), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule